// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This unit holds two 16-bit data pointers and a small select register that chooses which pointer is active. The active pointer always appears on a 16-bit output that feeds an address path. An instruction decoder can load a full 16-bit value into the active pointer, or increment it, with one-cycle commands. Neither command touches the pointer that is not selected.

Every pointer byte can also be reached directly over an 8-bit special-function-register bus. The bus has an address, write data, a write strobe and registered read data. A direct byte access always reaches the register named by its address, whatever the select bit holds. Byte writes, 16-bit commands and select changes may arrive in the same cycle. Fixed priorities settle these collisions so that the result is always defined.

Top module: `dptr_pair_unit`

## Requirements
- R1: After reset, all four pointer bytes are 00H, the select bit is 0 and `ptr_out` is 0000H.
- R2: Pointer 0 low and high bytes sit at 82H and 83H. Pointer 1 low and high bytes sit at 84H and 85H. A bus write at one of these addresses changes exactly that byte, whatever the select bit is.
- R3: The select register is at A2H, and its bit 0 is the select bit. Bits 7:1 always read 0, and writes to those bits are ignored.
- R4: `ptr_out` equals pointer 0 when the select bit is 0 and pointer 1 when it is 1.
- R5: `cmd_inc` adds one to the active pointer, carrying from the low byte into the high byte, and wraps FFFFH to 0000H. The inactive pointer is unchanged.
- R6: `cmd_load` writes `cmd_load_val` into the active pointer only.
- R7: When `cmd_load` and `cmd_inc` are both high in one cycle, the load takes effect and the increment is dropped.
- R8: A byte write that hits the active pointer in the same cycle as a load or increment wins. The written byte takes the bus data, the other byte of that pointer keeps its value, and the command is dropped. A byte write to the inactive pointer and a command to the active pointer in one cycle both take effect.
- R9: A command issued in the same cycle as a select write acts on the pointer that was selected before that write. The new selection applies from the next cycle.
- R10: `sfr_rdata` is registered. It shows the addressed byte one clock after the address is presented, and that value reflects the state before any write made in the same cycle. Addresses outside 82H–85H and A2H read 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_rdata | output | 8 | Register bus read data, one cycle after the address |
| cmd_load | input | 1 | Load `cmd_load_val` into the active pointer |
| cmd_inc | input | 1 | Increment the active pointer |
| cmd_load_val | input | 16 | Value for the load command |
| ptr_out | output | 16 | Currently active pointer |

## Verification
Two kinds of operation can land in the same cycle and fight over one pointer: a direct bus write from the register side, and a load or increment from the decoder side. The bench provokes this by raising both in one cycle. It does so against the active pointer (both bytes, with load and with increment) and against the inactive one. It then reads both pointers back over the bus and compares them with values worked out from the priority rule. The same approach covers a select write that coincides with an increment, where the bench checks that the pointer selected before the write is the one that moved.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  // Resolved action for one pointer bank in one cycle, highest priority first.
  typedef enum logic [2:0] {
    BANK_HOLD    = 3'd0,
    BANK_WR_LO   = 3'd1,
    BANK_WR_HI   = 3'd2,
    BANK_LOAD    = 3'd3,
    BANK_INC     = 3'd4
  } bank_op_e;

  function automatic bank_op_e resolve_op(input logic wr_lo, input logic wr_hi,
                                          input logic load, input logic inc);
    bank_op_e op;
    if (wr_lo)      op = BANK_WR_LO;
    else if (wr_hi) op = BANK_WR_HI;
    else if (load)  op = BANK_LOAD;
    else if (inc)   op = BANK_INC;
    else            op = BANK_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/dptr_bank.sv
module dptr_bank #(
  parameter int BYTE_W = 8,
  localparam int PTR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              do_load,
  input  logic              do_inc,
  input  logic [PTR_W-1:0]  load_val,
  output logic [PTR_W-1:0]  val
);
  import dptr_pkg::*;

  bank_op_e op;
  logic [PTR_W-1:0] val_q;

  always_comb op = resolve_op(wr_lo, wr_hi, do_load, do_inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else begin
      case (op)
        BANK_WR_LO: val_q[BYTE_W-1:0]     <= wdata;
        BANK_WR_HI: val_q[PTR_W-1:BYTE_W] <= wdata;
        BANK_LOAD:  val_q                 <= load_val;
        BANK_INC:   val_q                 <= val_q + 1'b1;
        default:    val_q                 <= val_q;
      endcase
    end
  end

  assign val = val_q;
endmodule

// File: rtl/dptr_sel_reg.sv
module dptr_sel_reg #(
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)        sel_q <= '0;
    else if (wr_en) sel_q <= wdata;
  end

  assign sel = sel_q;
endmodule

// File: rtl/dptr_rd_port.sv
module dptr_rd_port #(
  parameter int NUM_BANKS = 2,
  parameter int BYTE_W    = 8,
  parameter int SEL_W     = 1,
  localparam int PTR_W    = 2 * BYTE_W
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_BANKS-1:0]             hit_lo,
  input  logic [NUM_BANKS-1:0]             hit_hi,
  input  logic                             hit_sel,
  input  logic [NUM_BANKS-1:0][PTR_W-1:0]  bank_val,
  input  logic [SEL_W-1:0]                 sel,
  output logic [BYTE_W-1:0]                rdata
);
  logic [BYTE_W-1:0] rd_next;
  logic [BYTE_W-1:0] rd_q;

  // Address hits are mutually exclusive, so an OR tree replaces a priority chain.
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (hit_lo[i]) rd_next = rd_next | bank_val[i][BYTE_W-1:0];
      if (hit_hi[i]) rd_next = rd_next | bank_val[i][PTR_W-1:BYTE_W];
    end
    if (hit_sel) rd_next = rd_next | BYTE_W'(sel);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/dptr_pair_unit.sv
module dptr_pair_unit #(
  parameter int              NUM_BANKS = 2,
  parameter int              BYTE_W    = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h82,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'hA2,
  localparam int             PTR_W     = 2 * BYTE_W,
  localparam int             SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [BYTE_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic [BYTE_W-1:0] sfr_rdata,
  input  logic              cmd_load,
  input  logic              cmd_inc,
  input  logic [PTR_W-1:0]  cmd_load_val,
  output logic [PTR_W-1:0]  ptr_out
);

  logic [SEL_W-1:0]                sel_q;
  logic [NUM_BANKS-1:0]            hit_lo;
  logic [NUM_BANKS-1:0]            hit_hi;
  logic                            hit_sel;
  logic [NUM_BANKS-1:0][PTR_W-1:0] bank_val;

  assign hit_sel = (sfr_addr == SEL_ADDR);

  dptr_sel_reg #(.SEL_W(SEL_W)) sel_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (sfr_we && hit_sel),
    .wdata (sfr_wdata[SEL_W-1:0]),
    .sel   (sel_q)
  );

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(int'(BASE_ADDR) + 2 * gi);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(int'(BASE_ADDR) + 2 * gi + 1);

    logic is_active;

    assign hit_lo[gi] = (sfr_addr == LO_A);
    assign hit_hi[gi] = (sfr_addr == HI_A);
    assign is_active  = (sel_q == SEL_W'(gi));

    dptr_bank #(.BYTE_W(BYTE_W)) bank_i (
      .clk      (clk),
      .rst      (rst),
      .wr_lo    (sfr_we && hit_lo[gi]),
      .wr_hi    (sfr_we && hit_hi[gi]),
      .wdata    (sfr_wdata),
      .do_load  (cmd_load && is_active),
      .do_inc   (cmd_inc && is_active),
      .load_val (cmd_load_val),
      .val      (bank_val[gi])
    );
  end

  dptr_rd_port #(
    .NUM_BANKS (NUM_BANKS),
    .BYTE_W    (BYTE_W),
    .SEL_W     (SEL_W)
  ) rd_i (
    .clk      (clk),
    .rst      (rst),
    .hit_lo   (hit_lo),
    .hit_hi   (hit_hi),
    .hit_sel  (hit_sel),
    .bank_val (bank_val),
    .sel      (sel_q),
    .rdata    (sfr_rdata)
  );

  assign ptr_out = bank_val[sel_q];

endmodule

// File: rtl/dptr_pair_chk.sv
module dptr_pair_chk #(
  parameter int                BYTE_W   = 8,
  parameter int                ADDR_W   = 8,
  parameter int                SEL_W    = 1,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'hA2,
  localparam int               PTR_W    = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [SEL_W-1:0]  sfr_wsel,
  input logic              sfr_we,
  input logic [BYTE_W-1:0] sfr_rdata,
  input logic              cmd_load,
  input logic              cmd_inc,
  input logic [PTR_W-1:0]  cmd_load_val,
  input logic [PTR_W-1:0]  ptr_out,
  input logic [SEL_W-1:0]  sel
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (ptr_out == '0));

  // R5
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_inc && !cmd_load && !sfr_we) |=> (ptr_out == $past(ptr_out + PTR_W'(1))));

  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_load && !sfr_we) |=> (ptr_out == $past(cmd_load_val)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_load && !cmd_inc && !sfr_we) |=> $stable(ptr_out));

  // R3
  sel_write_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_we && sfr_addr == SEL_ADDR) |=> (sel == $past(sfr_wsel)));

  // R3
  sel_read_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_addr == SEL_ADDR) |=>
      (sfr_rdata[BYTE_W-1:SEL_W] == '0 && sfr_rdata[SEL_W-1:0] == $past(sel)));

endmodule

bind dptr_pair_unit dptr_pair_chk #(
  .BYTE_W   (BYTE_W),
  .ADDR_W   (ADDR_W),
  .SEL_W    (SEL_W),
  .SEL_ADDR (SEL_ADDR)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .sfr_addr     (sfr_addr),
  .sfr_wsel     (sfr_wdata[SEL_W-1:0]),
  .sfr_we       (sfr_we),
  .sfr_rdata    (sfr_rdata),
  .cmd_load     (cmd_load),
  .cmd_inc      (cmd_inc),
  .cmd_load_val (cmd_load_val),
  .ptr_out      (ptr_out),
  .sel          (sel_q)
);

// File: tb/dptr_pair_unit_tb_top.sv
`timescale 1ns/1ps
module dptr_pair_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sfr_addr = '0;
  logic [7:0]  sfr_wdata = '0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_rdata;
  logic        cmd_load = 1'b0;
  logic        cmd_inc = 1'b0;
  logic [15:0] cmd_load_val = '0;
  logic [15:0] ptr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dptr_pair_unit dut_i (
    .clk          (clk),
    .rst          (rst),
    .sfr_addr     (sfr_addr),
    .sfr_wdata    (sfr_wdata),
    .sfr_we       (sfr_we),
    .sfr_rdata    (sfr_rdata),
    .cmd_load     (cmd_load),
    .cmd_inc      (cmd_inc),
    .cmd_load_val (cmd_load_val),
    .ptr_out      (ptr_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    sfr_we = 1'b0; cmd_load = 1'b0; cmd_inc = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a; sfr_we = 1'b0;
    @(negedge clk);
    d = sfr_rdata;
  endtask

  task automatic rd16(input int bank, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(8'(8'h82 + 2 * bank), lo);
    rd(8'(8'h83 + 2 * bank), hi);
    v = {hi, lo};
  endtask

  task automatic set16(input int bank, input logic [15:0] v);
    wr(8'(8'h82 + 2 * bank), v[7:0]);
    wr(8'(8'h83 + 2 * bank), v[15:8]);
  endtask

  task automatic ld(input logic [15:0] v);
    cmd_load = 1'b1; cmd_load_val = v;
    @(negedge clk);
    idle();
  endtask

  task automatic inc1();
    cmd_inc = 1'b1;
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL WATCHDOG actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    logic [15:0] vals [6];
    vals = '{16'h0000, 16'h00FF, 16'h12FF, 16'hFFFF, 16'h7FFF, 16'h0001};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 ptr_out", ptr_out, 16'h0000);
    for (int a = 8'h82; a <= 8'h85; a++) begin
      rd(8'(a), b); chk("R1 byte", {8'h00, b}, 16'h0000);
    end
    rd(8'hA2, b); chk("R1 select", {8'h00, b}, 16'h0000);

    // R2, R4: sweep pointer 0 bytes while pointer 1 is active
    wr(8'hA2, 8'h01);
    for (int v = 0; v < 256; v++) begin
      wr(8'h82, 8'(v));
      wr(8'h83, 8'(~v));
      rd(8'h82, b); chk("R2 p0 lo", {8'h00, b}, 16'(v));
      rd(8'h83, b); chk("R2 p0 hi", {8'h00, b}, {8'h00, 8'(~v)});
      chk("R4 ptr_out follows p1", ptr_out, 16'h0000);
    end
    // sweep pointer 1 while pointer 0 (now 00FFH... last v=255 -> lo FF hi 00) is active
    wr(8'hA2, 8'h00);
    for (int v = 0; v < 256; v++) begin
      wr(8'h84, 8'(v + 3));
      wr(8'h85, 8'(v));
      rd(8'h84, b); chk("R2 p1 lo", {8'h00, b}, {8'h00, 8'(v + 3)});
      rd(8'h85, b); chk("R2 p1 hi", {8'h00, b}, 16'(v));
      chk("R4 ptr_out follows p0", ptr_out, 16'h00FF);
    end

    // R3: select register, unimplemented bits
    wr(8'hA2, 8'hFF);
    rd(8'hA2, b); chk("R3 sel FF", {8'h00, b}, 16'h0001);
    chk("R4 p1 active", ptr_out, 16'hFF02);
    wr(8'hA2, 8'hFE);
    rd(8'hA2, b); chk("R3 sel FE", {8'h00, b}, 16'h0000);
    chk("R4 p0 active", ptr_out, 16'h00FF);

    // R5, R6: load and increment on each bank, other bank untouched
    for (int s = 0; s < 2; s++) begin
      wr(8'hA2, 8'(s));
      set16(1 - s, 16'hA5C3);
      foreach (vals[k]) begin
        ld(vals[k]);
        chk("R6 load", ptr_out, vals[k]);
        inc1();
        chk("R5 inc", ptr_out, vals[k] + 16'd1);
        rd16(s, w); chk("R5 active via bus", w, vals[k] + 16'd1);
        rd16(1 - s, w); chk("R5 R6 inactive kept", w, 16'hA5C3);
      end
      for (int n = 0; n < 3; n++) inc1();
      chk("R5 repeated inc", ptr_out, 16'h0005);
    end

    // R7: load beats increment
    wr(8'hA2, 8'h00);
    cmd_load = 1'b1; cmd_inc = 1'b1; cmd_load_val = 16'h3456;
    @(negedge clk); idle();
    chk("R7 load wins", ptr_out, 16'h3456);

    // R8: byte write versus command on the active pointer
    set16(0, 16'h12FF);
    sfr_addr = 8'h82; sfr_wdata = 8'hAA; sfr_we = 1'b1; cmd_inc = 1'b1;
    @(negedge clk); idle();
    chk("R8 lo write beats inc", ptr_out, 16'h12AA);
    sfr_addr = 8'h83; sfr_wdata = 8'h55; sfr_we = 1'b1;
    cmd_load = 1'b1; cmd_load_val = 16'hBEEF;
    @(negedge clk); idle();
    chk("R8 hi write beats load", ptr_out, 16'h55AA);
    // byte write to inactive pointer with inc on active one
    set16(1, 16'h1000);
    sfr_addr = 8'h84; sfr_wdata = 8'h77; sfr_we = 1'b1; cmd_inc = 1'b1;
    @(negedge clk); idle();
    chk("R8 active still incs", ptr_out, 16'h55AB);
    rd16(1, w); chk("R8 inactive byte written", w, 16'h1077);

    // R9: select write and increment in one cycle
    set16(0, 16'h0010);
    set16(1, 16'h0020);
    sfr_addr = 8'hA2; sfr_wdata = 8'h01; sfr_we = 1'b1; cmd_inc = 1'b1;
    @(negedge clk); idle();
    chk("R9 new sel visible", ptr_out, 16'h0020);
    rd16(0, w); chk("R9 old pointer incremented", w, 16'h0011);
    rd16(1, w); chk("R9 new pointer untouched", w, 16'h0020);

    // R10: unmapped reads, read during write
    rd(8'h81, b); chk("R10 unmapped 81", {8'h00, b}, 16'h0000);
    rd(8'h86, b); chk("R10 unmapped 86", {8'h00, b}, 16'h0000);
    rd(8'hA3, b); chk("R10 unmapped A3", {8'h00, b}, 16'h0000);
    rd(8'h00, b); chk("R10 unmapped 00", {8'h00, b}, 16'h0000);
    sfr_addr = 8'h82; sfr_wdata = 8'h99; sfr_we = 1'b1;
    @(negedge clk); idle();
    chk("R10 old data on write", {8'h00, sfr_rdata}, 16'h0011);
    rd(8'h82, b); chk("R10 new data next", {8'h00, b}, 16'h0099);

    // R1: reset again clears everything
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R1 ptr_out after rerun", ptr_out, 16'h0000);
    rd16(1, w); chk("R1 p1 after reset", w, 16'h0000);
    rd(8'hA2, b); chk("R1 sel after reset", {8'h00, b}, 16'h0000);

    finish_run();
  end

endmodule